// File: doc/BRIEF.md
# Dissemination Barrier Synchronizer

This block lets a group of agents meet at a common point in a program. Each agent has its own arrive input and release output. An agent pulses arrive when it reaches the meeting point. It then receives a one-cycle release pulse only after every agent in the group has arrived. No central arrival counter exists. Each agent runs a fixed number of pairwise exchange rounds. In every round it raises a flag held for a partner agent, then waits until its own flag for that round has been raised. Agents may therefore be in different rounds at the same moment and may finish at different times. Even so, none finishes before all have entered.

Every agent keeps a local sense bit and a parity bit, and these select one of two flag banks. Because the flags never need to be cleared, the barrier can be entered again right away. An agent may re-arrive in the cycle after its release while slower agents are still draining the previous episode. The group size is a parameter from 2 to 16 and need not be a power of two.

Top module: `dissem_barrier`

## Requirements
- R1: The barrier runs ROUNDS = ceil(log2 NUM_AGENTS) rounds. Each round takes two cycles per agent: one to signal, then one or more to test. An agent whose arrive is sampled at clock edge k, with all others already inside, raises release after edge k + 2*ROUNDS.
- R2: In round r, agent i signals agent (i + 2^r) mod NUM_AGENTS. This partner rule also applies when NUM_AGENTS is not a power of two.
- R3: Each agent owns one flag per round in each of two banks. An agent leaves round r only once its own flag for round r in its current bank differs from its local sense.
- R4: Signalling writes the inverse of the signalling agent's local sense into the partner's flag. The local sense inverts at a release only when the parity bit was 1 before that release.
- R5: The parity bit of an agent toggles at every release of that agent and at no other time. This lets consecutive episodes run back to back with no clearing of flags.
- R6: No agent is released before every agent has had its arrive accepted. Once the last arrive is accepted at edge k, every agent is released by edge k + 2*ROUNDS.
- R7: Release is a pulse one cycle wide. Each agent gets exactly one release per episode.
- R8: An arrive pulse on an agent that is already inside the barrier is ignored. It neither restarts the agent's rounds nor causes an extra release.
- R9: Synchronous active-high reset clears all flags, senses, parities and round state. Release stays low until a complete episode has taken place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arrive_i | input | NUM_AGENTS | One bit per agent; a high sample means the agent enters the barrier |
| release_o | output | NUM_AGENTS | One bit per agent; registered single-cycle pulse when the agent leaves |

## Verification
The bench goes after the window in which some agents have arrived and one has not. A design with a wrong partner offset or a missing round would release an early agent there, and the bench watches for any release in that window. Episodes run back to back with many arrival skews, so every combination of parity and sense is reached. A design that inverted the sense on every release, or picked the wrong bank, would then hang or release too early in a later episode. Duplicate arrive pulses are sent to agents already inside, at the start and in the middle of an episode. A design that restarted the rounds would deliver a late or missing release. The last arriver's release cycle is checked exactly, which catches a design that skips the signal cycle or checks the flag too early.

// File: rtl/dissem_pkg.sv
package dissem_pkg;

  // Agent that writes the flag owned by dst in round rnd.
  function automatic int source_of(input int dst, input int rnd, input int n);
    return (dst + n - ((1 << rnd) % n)) % n;
  endfunction

  // Round counter width for a given round count.
  function automatic int cnt_width(input int rounds);
    return (rounds > 1) ? $clog2(rounds) : 1;
  endfunction

endpackage

// File: rtl/dissem_flag_store.sv
module dissem_flag_store #(
  parameter int ROUNDS = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ROUNDS-1:0]        wr_en,
  input  logic [ROUNDS-1:0]        wr_bank,
  input  logic [ROUNDS-1:0]        wr_val,
  output logic [1:0][ROUNDS-1:0]   flags_o
);

  logic [1:0][ROUNDS-1:0] flags_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
    end else begin
      for (int r = 0; r < ROUNDS; r++) begin
        for (int b = 0; b < 2; b++) begin
          if (wr_en[r] && (wr_bank[r] == b[0])) begin
            flags_q[b][r] <= wr_val[r];
          end
        end
      end
    end
  end

  assign flags_o = flags_q;

endmodule

// File: rtl/dissem_agent.sv
module dissem_agent #(
  parameter int ROUNDS = 3,
  parameter int RCW    = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           arrive,
  input  logic           own_flag,
  output logic           busy_o,
  output logic [RCW-1:0] round_o,
  output logic           parity_o,
  output logic           sense_o,
  output logic           send_o,
  output logic           rel_o
);

  localparam logic [RCW-1:0] LAST = RCW'(ROUNDS - 1);

  logic           busy_q;
  logic           sent_q;
  logic [RCW-1:0] round_q;
  logic           parity_q;
  logic           sense_q;
  logic           rel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      sent_q   <= 1'b0;
      round_q  <= '0;
      parity_q <= 1'b0;
      sense_q  <= 1'b0;
      rel_q    <= 1'b0;
    end else begin
      rel_q <= 1'b0;
      if (!busy_q) begin
        if (arrive) begin
          busy_q  <= 1'b1;
          round_q <= '0;
          sent_q  <= 1'b0;
        end
      end else if (!sent_q) begin
        sent_q <= 1'b1;
      end else if (own_flag != sense_q) begin
        if (round_q == LAST) begin
          busy_q   <= 1'b0;
          rel_q    <= 1'b1;
          parity_q <= ~parity_q;
          if (parity_q) begin
            sense_q <= ~sense_q;
          end
        end else begin
          round_q <= round_q + 1'b1;
          sent_q  <= 1'b0;
        end
      end
    end
  end

  assign busy_o   = busy_q;
  assign round_o  = round_q;
  assign parity_o = parity_q;
  assign sense_o  = sense_q;
  assign send_o   = busy_q && !sent_q;
  assign rel_o    = rel_q;

endmodule

// File: rtl/dissem_barrier.sv
module dissem_barrier #(
  parameter int NUM_AGENTS = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_AGENTS-1:0] arrive_i,
  output logic [NUM_AGENTS-1:0] release_o
);

  localparam int ROUNDS = $clog2(NUM_AGENTS);
  localparam int RCW    = dissem_pkg::cnt_width(ROUNDS);

  logic [NUM_AGENTS-1:0]                   agent_busy;
  logic [NUM_AGENTS-1:0][RCW-1:0]          agent_round;
  logic [NUM_AGENTS-1:0]                   agent_parity;
  logic [NUM_AGENTS-1:0]                   agent_sense;
  logic [NUM_AGENTS-1:0]                   agent_send;
  logic [NUM_AGENTS-1:0]                   agent_own_flag;
  logic [NUM_AGENTS-1:0][ROUNDS-1:0]       wr_en;
  logic [NUM_AGENTS-1:0][ROUNDS-1:0]       wr_bank;
  logic [NUM_AGENTS-1:0][ROUNDS-1:0]       wr_val;
  logic [NUM_AGENTS-1:0][1:0][ROUNDS-1:0]  flag_bits;

  for (genvar i = 0; i < NUM_AGENTS; i++) begin : g_agent
    dissem_agent #(
      .ROUNDS (ROUNDS),
      .RCW    (RCW)
    ) u_agent (
      .clk      (clk),
      .rst      (rst),
      .arrive   (arrive_i[i]),
      .own_flag (agent_own_flag[i]),
      .busy_o   (agent_busy[i]),
      .round_o  (agent_round[i]),
      .parity_o (agent_parity[i]),
      .sense_o  (agent_sense[i]),
      .send_o   (agent_send[i]),
      .rel_o    (release_o[i])
    );

    assign agent_own_flag[i] = flag_bits[i][agent_parity[i]][agent_round[i]];

    for (genvar r = 0; r < ROUNDS; r++) begin : g_round
      localparam int SRC = dissem_pkg::source_of(i, r, NUM_AGENTS);
      assign wr_en[i][r]   = agent_send[SRC] && (agent_round[SRC] == RCW'(r));
      assign wr_bank[i][r] = agent_parity[SRC];
      assign wr_val[i][r]  = ~agent_sense[SRC];
    end

    dissem_flag_store #(
      .ROUNDS (ROUNDS)
    ) u_flags (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_en[i]),
      .wr_bank (wr_bank[i]),
      .wr_val  (wr_val[i]),
      .flags_o (flag_bits[i])
    );
  end

endmodule

// File: rtl/dissem_barrier_chk.sv
module dissem_barrier_chk #(
  parameter int NUM_AGENTS = 6
) (
  input logic                                  clk,
  input logic                                  rst,
  input logic [NUM_AGENTS-1:0]                 arrive,
  input logic [NUM_AGENTS-1:0]                 rel,
  input logic [NUM_AGENTS-1:0]                 busy,
  input logic [NUM_AGENTS-1:0][dissem_pkg::cnt_width($clog2(NUM_AGENTS))-1:0] round_idx,
  input logic [NUM_AGENTS-1:0]                 parity,
  input logic [NUM_AGENTS-1:0]                 sense,
  input logic [NUM_AGENTS-1:0]                 own_flag
);

  localparam int ROUNDS = $clog2(NUM_AGENTS);

  for (genvar i = 0; i < NUM_AGENTS; i++) begin : g_chk
    assert_pulse_width_R7: assert property (@(posedge clk) disable iff (rst)
      rel[i] |=> !rel[i]);

    assert_parity_toggle_R5: assert property (@(posedge clk) disable iff (rst)
      rel[i] |-> (parity[i] != $past(parity[i])));

    assert_parity_hold_R5: assert property (@(posedge clk) disable iff (rst)
      !rel[i] |-> $stable(parity[i]));

    assert_sense_rule_R4: assert property (@(posedge clk) disable iff (rst)
      !$stable(sense[i]) |-> (rel[i] && $past(parity[i])));

    assert_advance_on_flag_R3: assert property (@(posedge clk) disable iff (rst)
      (busy[i] && $past(busy[i]) && (round_idx[i] != $past(round_idx[i])))
        |-> $past(own_flag[i] != sense[i]));

    assert_ignore_arrive_R8: assert property (@(posedge clk) disable iff (rst)
      (busy[i] && arrive[i]) |=> (rel[i] || (busy[i] && (round_idx[i] >= $past(round_idx[i])))));

    always @(posedge clk) begin
      if (!rst && busy[i]) begin
        assert_round_bound_R1: assert (int'(round_idx[i]) < ROUNDS);
      end
    end
  end

endmodule

bind dissem_barrier dissem_barrier_chk #(.NUM_AGENTS(NUM_AGENTS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .arrive    (arrive_i),
  .rel       (release_o),
  .busy      (agent_busy),
  .round_idx (agent_round),
  .parity    (agent_parity),
  .sense     (agent_sense),
  .own_flag  (agent_own_flag)
);

// File: tb/dissem_barrier_bench.sv
`timescale 1ns/1ps
module dissem_barrier_bench;

  localparam int NA     = 6;
  localparam int ROUNDS = $clog2(NA);
  localparam int RUN    = 16 + 2 * ROUNDS + 4;
  localparam int NVEC   = 8;

  // Arrival delay (cycles) per agent, agent 0 in the low nibble.
  localparam logic [4*NA-1:0] VEC [NVEC] = '{
    24'h000000, 24'h543210, 24'h012345, 24'hF00000,
    24'h222229, 24'h70A3C1, 24'h000001, 24'h333333
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NA-1:0] arrive_i = '0;
  logic [NA-1:0] release_o;
  int            cyc = 0;
  int            errors = 0;
  int            checks = 0;
  bit            done = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dissem_barrier #(.NUM_AGENTS(NA)) u_dissem_barrier (
    .clk       (clk),
    .rst       (rst),
    .arrive_i  (arrive_i),
    .release_o (release_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Drive one episode; caller is at a negedge. dup_agent re-pulses arrive at dup_t.
  task automatic episode(input logic [4*NA-1:0] dl, input int dup_agent,
                         input int dup_t, input bit exact);
    int c0, last, last_edge;
    int cnt [NA];
    int rc  [NA];
    c0 = cyc;
    last = 0;
    for (int a = 0; a < NA; a++) begin
      cnt[a] = 0;
      rc[a]  = -1;
      if (int'(dl[4*a +: 4]) > last) last = int'(dl[4*a +: 4]);
    end
    last_edge = c0 + last + 1;
    for (int t = 0; t <= RUN; t++) begin
      for (int a = 0; a < NA; a++) begin
        if (release_o[a]) begin
          cnt[a]++;
          rc[a] = cyc;
        end
      end
      for (int a = 0; a < NA; a++) begin
        arrive_i[a] = (int'(dl[4*a +: 4]) == t) || ((a == dup_agent) && (t == dup_t));
      end
      @(negedge clk);
    end
    arrive_i = '0;
    for (int a = 0; a < NA; a++) begin
      // R7: exactly one single-cycle release per episode
      chk(cnt[a] == 1, "R7 release count", cnt[a], 1);
      // R6: nothing before the last accepted arrive
      chk(rc[a] > last_edge, "R6 early release", rc[a], last_edge + 1);
      // R6/R2: partner chain completes within 2*ROUNDS after last arrive
      chk(rc[a] <= last_edge + 2 * ROUNDS, "R6 R2 late release", rc[a], last_edge + 2 * ROUNDS);
      if (exact && (int'(dl[4*a +: 4]) == last)) begin
        // R1: last arriver spends two cycles per round
        chk(rc[a] == last_edge + 2 * ROUNDS, "R1 last arriver latency", rc[a], last_edge + 2 * ROUNDS);
      end
    end
  endtask

  initial begin
    #1_600_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R9: release low while reset held
    chk(release_o == '0, "R9 reset release", int'(release_o), 0);
    rst = 1'b0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk(release_o == '0, "R9 idle after reset", int'(release_o), 0);
    end

    // Table walk: back-to-back episodes cover all parity/sense pairs (R5, R4, R3).
    for (int v = 0; v < NVEC; v++) begin
      episode(VEC[v], -1, 0, 1'b1);
    end

    // R8: duplicate arrive on an agent already inside (start and mid-episode).
    episode(24'h666660, 0, 3, 1'b1);
    episode(24'h444444, 2, 9, 1'b1);
    episode(24'h000000, 5, 2, 1'b1);

    // R6: five agents inside, agent 5 withheld; no one may leave.
    arrive_i = 6'b011111;
    @(negedge clk);
    arrive_i = '0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      chk(release_o == '0, "R6 withheld agent", int'(release_o), 0);
    end
    // Agent 5 arrives; repeated pulses to agents 0..4 are ignored (R8).
    episode(24'h000000, -1, 0, 1'b0);

    // R5: parity/sense still coherent afterwards.
    episode(24'h102030, -1, 0, 1'b1);
    episode(24'h000000, -1, 0, 1'b1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule